// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a processor core in dedicated storage of 31 entries, each 21 bits wide. A 5-bit pointer selects the top entry. A pointer value of 0 means the stack is empty, and no storage sits behind that value. A push first advances the pointer and then stores the supplied address in the new slot. A pop presents the entry under the pointer as the return address and then moves the pointer back by one.

Software sees a byte-wide window through a 2-bit selector. Through it, software can read or write the pointer and each of the three bytes of the top entry. This lets a program save the stack to its own memory and later restore it. Three flags report the stack's state: full, a sticky overflow, and a sticky underflow. The block only raises these flags. Any reaction to them is left to the surrounding core.

Top module: `retStack`

## Requirements
- R1: After reset the pointer is 0, all flags are 0, `topAddr` is 0 and every storage entry is 0.
- R2: A push alone (pushReq=1, popReq=0) with the pointer below 31 increments the pointer and stores `pushAddr` in the new top slot, so that `topAddr` shows it from the next cycle.
- R3: `topAddr` is combinationally the entry under the pointer (0 when the pointer is 0). A pop alone with the pointer above 0 decrements the pointer at the clock edge, so the value on `topAddr` during the pop cycle is the return address.
- R4: `stackFull` is 1 exactly when the pointer equals 31.
- R5: A push alone while the pointer is 31 sets `overflowFlag` and leaves the pointer and all entries unchanged.
- R6: A pop alone while the pointer is 0 sets `underflowFlag`, `topAddr` reads 0, and the pointer stays 0.
- R7: Both sticky flags stay set until reset or a cycle with `swClrFlags`=1, which clears both. A flag that is set in the same cycle as a clear wins over the clear.
- R8: Selector code 0 addresses the pointer. A read returns {3'b000, pointer}, and a write loads `swWdata[4:0]` into the pointer.
- R9: Selector codes 1, 2 and 3 address the top entry's bits [7:0], [15:8] and {3'b000, bits [20:16]}. A write replaces only that field, taking `swWdata[4:0]` for code 3.
- R10: While the pointer is 0, reads of selector codes 1 to 3 return 0 and writes to them change no entry.
- R11: A push and a pop requested in the same cycle do nothing: the pointer, the entries and the flags all keep their values.
- R12: A software write takes effect only in a cycle where both pushReq and popReq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Push strobe |
| popReq | input | 1 | Pop strobe |
| pushAddr | input | 21 | Return address to push |
| topAddr | output | 21 | Entry under the pointer (return address on a pop) |
| swSel | input | 2 | Software window select: 0 pointer, 1 low, 2 high, 3 upper |
| swWr | input | 1 | Software write strobe |
| swWdata | input | 8 | Software write byte |
| swRdata | output | 8 | Software read byte for the selected field |
| swClrFlags | input | 1 | Clears the overflow and underflow flags |
| stkPtr | output | 5 | Current pointer |
| stackFull | output | 1 | Pointer equals 31 |
| overflowFlag | output | 1 | Sticky: push attempted while full |
| underflowFlag | output | 1 | Sticky: pop attempted while empty |

## Verification
The assertions check every cycle that the pointer steps by exactly one on an accepted push or pop, and that it holds on a collision or at a boundary. They also check that the sticky flags do not drop without a clear, and that a push or byte write lands in the addressed slot one cycle later. The bench scenarios cover what a single cycle cannot show. These include a full fill to 31 and a drain back to empty with matching return values, and restoring a stack through the byte window. They also show that ignored writes at pointer 0 or during a strobe leave no trace when the data is read back later.

// File: rtl/retstack_pkg.sv
package retstack_pkg;

  typedef enum logic [1:0] {
    SEL_PTR   = 2'd0,
    SEL_LOW   = 2'd1,
    SEL_HIGH  = 2'd2,
    SEL_UPPER = 2'd3
  } swSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pushWr;
    logic lowWr;
    logic highWr;
    logic upperWr;
  } stkStrobe_t;

endpackage

// File: rtl/retStackCtrl.sv
module retStackCtrl
  import retstack_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushReq,
  input  logic          popReq,
  input  logic [1:0]    swSel,
  input  logic          swWr,
  input  logic [PW-1:0] swPtrData,
  input  logic          swClrFlags,
  output stkStrobe_t    strobes,
  output logic [PW-1:0] wrIdx,
  output logic [PW-1:0] ptr,
  output logic          isFull,
  output logic          overflowFlag,
  output logic          underflowFlag
);

  localparam logic [PW-1:0] PTR_MAX  = PW'(DEPTH);
  localparam logic [PW-1:0] PTR_ZERO = '0;
  localparam logic [PW-1:0] PTR_ONE  = PW'(1);

  logic pushOnly, popOnly, idle, swOk, isEmpty;
  logic setOv, setUn;
  logic [PW-1:0] ptrNext;

  assign pushOnly = pushReq & ~popReq;
  assign popOnly  = popReq & ~pushReq;
  assign idle     = ~pushReq & ~popReq;
  assign swOk     = idle & swWr;
  assign isEmpty  = (ptr == PTR_ZERO);
  assign isFull   = (ptr == PTR_MAX);
  assign setOv    = pushOnly & isFull;
  assign setUn    = popOnly & isEmpty;

  always_comb begin
    ptrNext = ptr;
    if (pushOnly && !isFull)
      ptrNext = ptr + PTR_ONE;
    else if (popOnly && !isEmpty)
      ptrNext = ptr - PTR_ONE;
    else if (swOk && swSel == SEL_PTR)
      ptrNext = swPtrData;
  end

  always_comb begin
    strobes.pushWr  = pushOnly & ~isFull;
    strobes.lowWr   = swOk & ~isEmpty & (swSel == SEL_LOW);
    strobes.highWr  = swOk & ~isEmpty & (swSel == SEL_HIGH);
    strobes.upperWr = swOk & ~isEmpty & (swSel == SEL_UPPER);
    // push writes the slot the pointer moves to; byte writes hit the current top
    wrIdx = strobes.pushWr ? ptr : (ptr - PTR_ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr           <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      ptr           <= ptrNext;
      overflowFlag  <= setOv | (overflowFlag & ~swClrFlags);
      underflowFlag <= setUn | (underflowFlag & ~swClrFlags);
    end
  end

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && ptr != PTR_MAX) |=> (ptr == $past(ptr) + PTR_ONE));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && ptr != PTR_ZERO) |=> (ptr == $past(ptr) - PTR_ONE));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && ptr == PTR_MAX) |=> (overflowFlag && ptr == PTR_MAX));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && ptr == PTR_ZERO) |=> (underflowFlag && ptr == PTR_ZERO));

  // R11
  collide_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> $stable(ptr));

  // R7
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !swClrFlags) |=> overflowFlag);

  // R7
  un_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underflowFlag && !swClrFlags) |=> underflowFlag);

  // R12
  sw_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pushReq || popReq) && swWr && swSel == SEL_PTR && pushReq == popReq) |=> $stable(ptr));

endmodule

// File: rtl/retStackData.sv
module retStackData
  import retstack_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  stkStrobe_t    strobes,
  input  logic [PW-1:0] wrIdx,
  input  logic [PW-1:0] ptr,
  input  logic [AW-1:0] pushAddr,
  input  logic [1:0]    swSel,
  input  logic [7:0]    swWdata,
  output logic [AW-1:0] topAddr,
  output logic [7:0]    swRdata
);

  localparam int UW = AW - 16;
  localparam logic [PW-1:0] PTR_ONE = PW'(1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] rdIdx;

  assign rdIdx = ptr - PTR_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strobes.pushWr)  mem[wrIdx]          <= pushAddr;
      if (strobes.lowWr)   mem[wrIdx][7:0]     <= swWdata;
      if (strobes.highWr)  mem[wrIdx][15:8]    <= swWdata;
      if (strobes.upperWr) mem[wrIdx][AW-1:16] <= swWdata[UW-1:0];
    end
  end

  always_comb begin
    topAddr = (ptr == '0) ? '0 : mem[rdIdx];
    case (swSel)
      SEL_PTR:   swRdata = 8'(ptr);
      SEL_LOW:   swRdata = topAddr[7:0];
      SEL_HIGH:  swRdata = topAddr[15:8];
      default:   swRdata = 8'(topAddr[AW-1:16]);
    endcase
  end

  // R2
  push_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pushWr |=> (mem[$past(wrIdx)] == $past(pushAddr)));

  // R9
  low_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lowWr |=> (mem[$past(wrIdx)][7:0] == $past(swWdata)));

endmodule

// File: rtl/retStack.sv
module retStack
  import retstack_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushReq,
  input  logic          popReq,
  input  logic [AW-1:0] pushAddr,
  output logic [AW-1:0] topAddr,
  input  logic [1:0]    swSel,
  input  logic          swWr,
  input  logic [7:0]    swWdata,
  output logic [7:0]    swRdata,
  input  logic          swClrFlags,
  output logic [PW-1:0] stkPtr,
  output logic          stackFull,
  output logic          overflowFlag,
  output logic          underflowFlag
);

  stkStrobe_t    strobes;
  logic [PW-1:0] wrIdx;

  retStackCtrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .pushReq       (pushReq),
    .popReq        (popReq),
    .swSel         (swSel),
    .swWr          (swWr),
    .swPtrData     (swWdata[PW-1:0]),
    .swClrFlags    (swClrFlags),
    .strobes       (strobes),
    .wrIdx         (wrIdx),
    .ptr           (stkPtr),
    .isFull        (stackFull),
    .overflowFlag  (overflowFlag),
    .underflowFlag (underflowFlag)
  );

  retStackData #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrIdx    (wrIdx),
    .ptr      (stkPtr),
    .pushAddr (pushAddr),
    .swSel    (swSel),
    .swWdata  (swWdata),
    .topAddr  (topAddr),
    .swRdata  (swRdata)
  );

endmodule

// File: tb/tb_retStack.sv
module tb_retStack;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushReq = 0, popReq = 0, swWr = 0, swClrFlags = 0;
  logic [20:0] pushAddr = '0;
  logic [1:0]  swSel = '0;
  logic [7:0]  swWdata = '0;
  logic [20:0] topAddr;
  logic [7:0]  swRdata;
  logic [4:0]  stkPtr;
  logic        stackFull, overflowFlag, underflowFlag;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [20:0] model [32];
  int  mPtr = 0;
  bit  mOv = 0, mUn = 0;

  retStack dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .pushAddr(pushAddr), .topAddr(topAddr), .swSel(swSel), .swWr(swWr),
    .swWdata(swWdata), .swRdata(swRdata), .swClrFlags(swClrFlags),
    .stkPtr(stkPtr), .stackFull(stackFull), .overflowFlag(overflowFlag),
    .underflowFlag(underflowFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] expTop();
    return (mPtr == 0) ? 21'd0 : model[mPtr];
  endfunction

  function automatic logic [7:0] expRd(input logic [1:0] sel);
    logic [20:0] t = expTop();
    case (sel)
      2'd0: return 8'(mPtr);
      2'd1: return t[7:0];
      2'd2: return t[15:8];
      default: return {3'b000, t[20:16]};
    endcase
  endfunction

  task automatic modelUpdate(input bit push, pop, input logic [20:0] addr,
                             input logic [1:0] sel, input bit wr,
                             input logic [7:0] wd, input bit clr);
    bit sOv = push && !pop && mPtr == 31;
    bit sUn = pop && !push && mPtr == 0;
    if (push && !pop) begin
      if (mPtr != 31) begin mPtr++; model[mPtr] = addr; end
    end else if (pop && !push) begin
      if (mPtr != 0) mPtr--;
    end else if (!push && !pop && wr) begin
      if (sel == 2'd0) mPtr = int'(wd[4:0]);
      else if (mPtr != 0) begin
        if (sel == 2'd1) model[mPtr][7:0] = wd;
        else if (sel == 2'd2) model[mPtr][15:8] = wd;
        else model[mPtr][20:16] = wd[4:0];
      end
    end
    mOv = sOv | (mOv & !clr);
    mUn = sUn | (mUn & !clr);
  endtask

  task automatic step(input bit push, pop, input logic [20:0] addr,
                      input logic [1:0] sel, input bit wr,
                      input logic [7:0] wd, input bit clr);
    @(negedge clk);
    pushReq = push; popReq = pop; pushAddr = addr;
    swSel = sel; swWr = wr; swWdata = wd; swClrFlags = clr;
    #1;
    chk("R3 topAddr", 32'(topAddr), 32'(expTop()));
    chk((sel == 2'd0) ? "R8 swRdata" : "R9 swRdata", 32'(swRdata), 32'(expRd(sel)));
    chk("R2 stkPtr", 32'(stkPtr), 32'(mPtr));
    chk("R4 stackFull", 32'(stackFull), 32'(mPtr == 31));
    chk("R5 overflowFlag", 32'(overflowFlag), 32'(mOv));
    chk("R6 underflowFlag", 32'(underflowFlag), 32'(mUn));
    @(posedge clk);
    modelUpdate(push, pop, addr, sel, wr, wd, clr);
  endtask

  task automatic idleStep(input logic [1:0] sel);
    step(0, 0, '0, sel, 0, '0, 0);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [20:0] saved;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) model[i] = '0;
    #(CLK_PERIOD * 3);
    // R1 reset state
    chk("R1 ptr", 32'(stkPtr), 0);
    chk("R1 flags", {29'd0, stackFull, overflowFlag, underflowFlag}, 0);
    chk("R1 top", 32'(topAddr), 0);
    @(negedge clk); rstN = 1;

    // R6 pop when empty
    step(0, 1, '0, 2'd1, 0, '0, 0);
    idleStep(2'd1);
    chk("R6 underflow set", 32'(underflowFlag), 1);
    // R10 byte write at pointer 0 ignored, read 0
    step(0, 0, '0, 2'd2, 1, 8'hAB, 0);
    idleStep(2'd2);
    chk("R10 tos read at 0", 32'(swRdata), 0);
    // R7 clear
    step(0, 0, '0, 2'd0, 0, '0, 1);
    idleStep(2'd0);
    chk("R7 cleared", 32'(underflowFlag), 0);

    // R2 fill to full
    for (int i = 1; i <= 31; i++) step(1, 0, 21'(i * 4099 + 7), 2'd1, 0, '0, 0);
    idleStep(2'd3);
    chk("R4 full at 31", 32'(stackFull), 1);
    saved = topAddr;
    // R5 push at full
    step(1, 0, 21'h1FFFFF, 2'd1, 0, '0, 0);
    idleStep(2'd1);
    chk("R5 top unchanged", 32'(topAddr), 32'(saved));
    // R7 set wins over clear, then sticky
    step(1, 0, 21'h0, 2'd1, 0, '0, 1);
    idleStep(2'd1);
    idleStep(2'd1);
    chk("R7 sticky", 32'(overflowFlag), 1);
    // R11 push and pop together
    step(1, 1, 21'h12345, 2'd0, 0, '0, 0);
    idleStep(2'd0);
    chk("R11 ptr held", 32'(stkPtr), 31);
    // R12 sw pointer write during pop ignored (pop applies)
    step(0, 1, '0, 2'd0, 1, 8'h03, 0);
    idleStep(2'd0);
    chk("R12 ptr after pop", 32'(stkPtr), 30);
    // R9 byte restore
    step(0, 0, '0, 2'd3, 1, 8'hFF, 0);
    step(0, 0, '0, 2'd2, 1, 8'h5A, 0);
    step(0, 0, '0, 2'd1, 1, 8'hC3, 0);
    idleStep(2'd3);
    chk("R9 top restored", 32'(topAddr), 32'h1F5AC3);
    // R3 drain, value on pop cycle is return address
    for (int i = 0; i < 30; i++) step(0, 1, '0, 2'd1, 0, '0, 0);
    idleStep(2'd0);
    chk("R3 drained", 32'(stkPtr), 0);
    // R8 pointer write
    step(0, 0, '0, 2'd0, 1, 8'hE5, 0);
    idleStep(2'd0);
    chk("R8 ptr write", 32'(swRdata), 32'h05);

    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      int pushPct = (ph % 3 == 0) ? 70 : ((ph % 3 == 1) ? 25 : 45);
      for (int c = 0; c < 600; c++) begin
        bit pu = ($urandom % 100) < pushPct;
        bit po = ($urandom % 100) < (95 - pushPct);
        bit wr = ($urandom % 100) < 12;
        bit cl = ($urandom % 100) < 3;
        logic [1:0] sel = 2'($urandom % 4);
        if (sel == 2'd0 && ($urandom % 4) != 0) sel = 2'd1;
        step(pu, po, 21'($urandom), sel, wr, 8'($urandom), cl);
      end
    end
    idleStep(2'd1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule